// File: doc/BRIEF.md
# Next-PC and Effective-Address Unit

This block resolves where a 16-bit machine goes next and which memory word it touches for every control-flow and data-movement instruction. When a `start` pulse arrives it takes in the instruction word, the current program counter, the value of the register named by the instruction's base field, the value of R7 and the three condition flags. It then returns the next program counter, an effective address with a flag that marks a memory access, and a request to write a link value into R7.

Every displacement is added to the incremented program counter (PC+1). The 9-, 11- and 6-bit displacement fields are sign-extended and the 8-bit service vector is zero-extended. Two instruction classes need one word from memory before they can finish. The pointer-through-memory load/store reads the operand address from memory, and the service call reads its routine address from memory. For these the unit drives a synchronous read port itself. It raises the read request in the start cycle, takes the returned word on the next edge and finishes one cycle later than the other classes. Arithmetic and logic results are computed elsewhere.

Top module: `flow_addr_unit`

## Requirements
- R1: While `rst` is high and after it falls, until the first completion, `done`, `link_we`, `mem_re`, `ea_valid` and `ea_indirect` are 0 and `next_pc` and `eff_addr` are 0.
- R2: Opcode bits[15:12]=0000 is a conditional branch. Bits[11:9] form a mask in the order n,z,p. The branch is taken when any mask bit and its matching flag are both 1. When taken, `next_pc` = PC+1+sext(bits[8:0]); otherwise `next_pc` = PC+1. A mask of 000 is never taken and a mask of 111 is taken whenever any flag is set.
- R3: Opcodes 0010 and 0011 give `eff_addr` = PC+1+sext(bits[8:0]) with `ea_valid`=1, `ea_indirect`=0 and `next_pc`=PC+1. For example, PC 0x4018 with field 0x1AF gives 0x3FC8.
- R4: Opcode 1110 returns PC+1+sext(bits[8:0]) on `eff_addr` with `ea_valid`=0 and does not read memory.
- R5: Opcodes 0110 and 0111 give `eff_addr` = base+sext(bits[5:0]), where the base is the register named by bits[8:6], with `ea_valid`=1.
- R6: Opcodes 1010 and 1011 read the word at PC+1+sext(bits[8:0]). `eff_addr` then equals that word, with `ea_valid`=1 and `ea_indirect`=1.
- R7: Opcode 1100 sets `next_pc` to the base register named by bits[8:6]. A field of 7 (return) uses `r7_val` and ignores `base_val`. No link write occurs.
- R8: Opcode 0100 raises `link_we` with `link_val`=PC+1. With bit 11 set, `next_pc`=PC+1+sext(bits[10:0]). With bit 11 clear, `next_pc` is the base register as sampled at start, which is the old R7 when the field is 7.
- R9: Opcode 1111 reads the word at zext(bits[7:0]), sets `next_pc` to that word and raises `link_we` with `link_val`=PC+1.
- R10: `done` is high for exactly one cycle. That cycle follows the start edge for instructions without a memory read and comes one cycle later for opcodes 1010, 1011 and 1111. A `start` during that wait is ignored.
- R11: Opcodes 0001, 0101, 1001, 1000 and 1101 give `next_pc`=PC+1, `ea_valid`=0 and `link_we`=0, and issue no read.
- R12: `mem_re` is high, with the read address on `mem_raddr`, only during an accepted start cycle of opcodes 1010, 1011 and 1111. The word on `mem_rdata` is expected one clock after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin processing the presented instruction |
| instr | input | 16 | Instruction word |
| pc | input | W | Address of the instruction |
| base_val | input | W | Value of the register named by bits[8:6] |
| r7_val | input | W | Current value of R7 |
| flag_n | input | 1 | Negative condition flag |
| flag_z | input | 1 | Zero condition flag |
| flag_p | input | 1 | Positive condition flag |
| mem_rdata | input | W | Read data, valid one clock after a request |
| mem_re | output | 1 | Read request |
| mem_raddr | output | W | Read address |
| next_pc | output | W | Resolved next program counter |
| eff_addr | output | W | Effective address or address-arithmetic result |
| ea_valid | output | 1 | The instruction accesses memory at `eff_addr` |
| ea_indirect | output | 1 | `eff_addr` was fetched from memory |
| link_we | output | 1 | Write `link_val` into R7 |
| link_val | output | W | Return address for R7 |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the read port returns data exactly one clock after a request, and that `start` is applied only when the previous instruction's completion has been seen or while the unit is waiting on memory. The bench's memory model answers every request on the next edge with a word computed from its address. The bench issues each instruction from an idle unit, and it raises `start` inside the wait cycle only on purpose, to exercise the busy case. The bench sweeps every branch mask against every flag combination, every service vector and every 6-bit displacement. It also strides through the 9- and 11-bit displacement ranges, including PC values that wrap past 0xFFFF.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int INSN_W = 16;
  localparam int OFF9_W = 9;
  localparam int OFF11_W = 11;
  localparam int OFF6_W = 6;
  localparam int VEC_W = 8;

  typedef enum logic [3:0] {
    OP_BR   = 4'b0000, OP_ADD  = 4'b0001, OP_LD   = 4'b0010, OP_ST   = 4'b0011,
    OP_JSR  = 4'b0100, OP_AND  = 4'b0101, OP_LDR  = 4'b0110, OP_STR  = 4'b0111,
    OP_RTI  = 4'b1000, OP_NOT  = 4'b1001, OP_LDI  = 4'b1010, OP_STI  = 4'b1011,
    OP_JMP  = 4'b1100, OP_RSV  = 4'b1101, OP_LEA  = 4'b1110, OP_TRAP = 4'b1111
  } opcode_e;

  // source of the next program counter
  typedef enum logic [1:0] {TGT_SEQ, TGT_REL, TGT_BASE, TGT_MEM} tgt_sel_e;

  typedef struct packed {
    tgt_sel_e tgt;
    logic     is_branch;
    logic     long_off;
    logic     ea_from_base;
    logic     ea_valid;
    logic     ea_ind;
    logic     link;
    logic     mem_rd;
    logic     rd_vec;
  } ctrl_t;
endpackage

// File: rtl/flow_decode.sv
module flow_decode
  import flow_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [INSN_W-1:0] instr,
  output ctrl_t             ctrl,
  output logic [W-1:0]      off9,
  output logic [W-1:0]      off11,
  output logic [W-1:0]      off6,
  output logic [W-1:0]      vec,
  output logic              base_is_r7
);
  opcode_e op;

  assign op = opcode_e'(instr[15:12]);
  assign off9  = {{(W-OFF9_W){instr[OFF9_W-1]}},   instr[OFF9_W-1:0]};
  assign off11 = {{(W-OFF11_W){instr[OFF11_W-1]}}, instr[OFF11_W-1:0]};
  assign off6  = {{(W-OFF6_W){instr[OFF6_W-1]}},   instr[OFF6_W-1:0]};
  assign vec   = {{(W-VEC_W){1'b0}},               instr[VEC_W-1:0]};
  assign base_is_r7 = (instr[8:6] == 3'd7);

  always_comb begin
    ctrl = '0;
    ctrl.tgt = TGT_SEQ;
    unique case (op)
      OP_BR: begin
        ctrl.tgt = TGT_REL;
        ctrl.is_branch = 1'b1;
      end
      OP_LD, OP_ST: ctrl.ea_valid = 1'b1;
      OP_LDR, OP_STR: begin
        ctrl.ea_valid = 1'b1;
        ctrl.ea_from_base = 1'b1;
      end
      OP_LDI, OP_STI: begin
        ctrl.ea_valid = 1'b1;
        ctrl.ea_ind = 1'b1;
        ctrl.mem_rd = 1'b1;
      end
      OP_JMP: ctrl.tgt = TGT_BASE;
      OP_JSR: begin
        ctrl.link = 1'b1;
        if (instr[11]) begin
          ctrl.tgt = TGT_REL;
          ctrl.long_off = 1'b1;
        end else begin
          ctrl.tgt = TGT_BASE;
        end
      end
      OP_TRAP: begin
        ctrl.tgt = TGT_MEM;
        ctrl.link = 1'b1;
        ctrl.mem_rd = 1'b1;
        ctrl.rd_vec = 1'b1;
      end
      default: ctrl.tgt = TGT_SEQ;
    endcase
  end
endmodule

// File: rtl/flow_addr_calc.sv
module flow_addr_calc
  import flow_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] pc,
  input  logic [W-1:0] base_op,
  input  logic [W-1:0] off9,
  input  logic [W-1:0] off11,
  input  logic [W-1:0] off6,
  input  logic [W-1:0] vec,
  input  logic [2:0]   cond_mask,
  input  logic         flag_n,
  input  logic         flag_z,
  input  logic         flag_p,
  input  tgt_sel_e     tgt,
  input  logic         is_branch,
  input  logic         long_off,
  input  logic         ea_from_base,
  input  logic         rd_vec,
  output logic [W-1:0] pc_inc,
  output logic [W-1:0] npc_now,
  output logic [W-1:0] ea_now,
  output logic [W-1:0] rd_addr
);
  logic [W-1:0] rel_short;
  logic [W-1:0] rel_long;
  logic [W-1:0] base_sum;
  logic         taken;

  assign pc_inc    = pc + W'(1);
  assign rel_short = pc_inc + off9;
  assign rel_long  = pc_inc + off11;
  assign base_sum  = base_op + off6;
  assign taken     = |(cond_mask & {flag_n, flag_z, flag_p});

  always_comb begin
    unique case (tgt)
      TGT_REL: begin
        if (long_off)       npc_now = rel_long;
        else if (is_branch) npc_now = taken ? rel_short : pc_inc;
        else                npc_now = rel_short;
      end
      TGT_BASE: npc_now = base_op;
      default:  npc_now = pc_inc;
    endcase
  end

  assign ea_now  = ea_from_base ? base_sum : rel_short;
  assign rd_addr = rd_vec ? vec : rel_short;
endmodule

// File: rtl/flow_seq.sv
module flow_seq
  import flow_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  tgt_sel_e     tgt,
  input  logic         c_ea_valid,
  input  logic         c_ea_ind,
  input  logic         c_link,
  input  logic         c_mem_rd,
  input  logic [W-1:0] npc_now,
  input  logic [W-1:0] ea_now,
  input  logic [W-1:0] pc_inc,
  input  logic [W-1:0] mem_rdata,
  output logic         mem_re,
  output logic [W-1:0] next_pc,
  output logic [W-1:0] eff_addr,
  output logic         ea_valid,
  output logic         ea_indirect,
  output logic         link_we,
  output logic [W-1:0] link_val,
  output logic         done
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e          st;
  logic [W-1:0] h_npc, h_ea, h_link;
  logic         h_tgt_mem, h_ev, h_ind, h_lw;

  assign mem_re = start && (st == ST_IDLE) && c_mem_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      next_pc <= '0; eff_addr <= '0; link_val <= '0;
      ea_valid <= 1'b0; ea_indirect <= 1'b0; link_we <= 1'b0; done <= 1'b0;
      h_npc <= '0; h_ea <= '0; h_link <= '0;
      h_tgt_mem <= 1'b0; h_ev <= 1'b0; h_ind <= 1'b0; h_lw <= 1'b0;
    end else begin
      done <= 1'b0;
      link_we <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start && c_mem_rd) begin
            st <= ST_WAIT;
            h_npc <= npc_now;
            h_ea <= ea_now;
            h_link <= pc_inc;
            h_tgt_mem <= (tgt == TGT_MEM);
            h_ev <= c_ea_valid;
            h_ind <= c_ea_ind;
            h_lw <= c_link;
          end else if (start) begin
            next_pc <= npc_now;
            eff_addr <= ea_now;
            ea_valid <= c_ea_valid;
            ea_indirect <= c_ea_ind;
            link_we <= c_link;
            link_val <= pc_inc;
            done <= 1'b1;
          end
        end
        ST_WAIT: begin
          st <= ST_IDLE;
          next_pc <= h_tgt_mem ? mem_rdata : h_npc;
          eff_addr <= h_ind ? mem_rdata : h_ea;
          ea_valid <= h_ev;
          ea_indirect <= h_ind;
          link_we <= h_lw;
          link_val <= h_link;
          done <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_wait_finishes_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |=> done);
  assert_read_then_wait_R12: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> (st == ST_WAIT) && !done);
  assert_link_on_done_R8: assert property (@(posedge clk) disable iff (rst)
    link_we |-> done);
  assert_indirect_accesses_R6: assert property (@(posedge clk) disable iff (rst)
    ea_indirect |-> ea_valid);
endmodule

// File: rtl/flow_addr_unit.sv
module flow_addr_unit
  import flow_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [INSN_W-1:0] instr,
  input  logic [W-1:0]      pc,
  input  logic [W-1:0]      base_val,
  input  logic [W-1:0]      r7_val,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_p,
  input  logic [W-1:0]      mem_rdata,
  output logic              mem_re,
  output logic [W-1:0]      mem_raddr,
  output logic [W-1:0]      next_pc,
  output logic [W-1:0]      eff_addr,
  output logic              ea_valid,
  output logic              ea_indirect,
  output logic              link_we,
  output logic [W-1:0]      link_val,
  output logic              done
);
  ctrl_t        ctrl;
  logic [W-1:0] off9, off11, off6, vec, base_op, pc_inc, npc_now, ea_now;
  logic         base_is_r7;

  flow_decode #(.W(W)) u_dec (
    .instr(instr), .ctrl(ctrl), .off9(off9), .off11(off11), .off6(off6),
    .vec(vec), .base_is_r7(base_is_r7)
  );

  assign base_op = base_is_r7 ? r7_val : base_val;

  flow_addr_calc #(.W(W)) u_calc (
    .pc(pc), .base_op(base_op), .off9(off9), .off11(off11), .off6(off6), .vec(vec),
    .cond_mask(instr[11:9]), .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p),
    .tgt(ctrl.tgt), .is_branch(ctrl.is_branch), .long_off(ctrl.long_off),
    .ea_from_base(ctrl.ea_from_base), .rd_vec(ctrl.rd_vec),
    .pc_inc(pc_inc), .npc_now(npc_now), .ea_now(ea_now), .rd_addr(mem_raddr)
  );

  flow_seq #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .tgt(ctrl.tgt),
    .c_ea_valid(ctrl.ea_valid), .c_ea_ind(ctrl.ea_ind), .c_link(ctrl.link),
    .c_mem_rd(ctrl.mem_rd), .npc_now(npc_now), .ea_now(ea_now), .pc_inc(pc_inc),
    .mem_rdata(mem_rdata), .mem_re(mem_re), .next_pc(next_pc), .eff_addr(eff_addr),
    .ea_valid(ea_valid), .ea_indirect(ea_indirect), .link_we(link_we),
    .link_val(link_val), .done(done)
  );

  assert_no_read_busy_R10: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re);
  assert_link_seq_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_re && instr[15:12] == 4'b1111) |=> ##1 link_we);
endmodule

// File: tb/flow_addr_unit_tb_top.sv
module flow_addr_unit_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic start;
  logic [15:0] instr, pc, base_val, r7_val, mem_rdata, mem_raddr;
  logic flag_n, flag_z, flag_p;
  logic mem_re, ea_valid, ea_indirect, link_we, done;
  logic [15:0] next_pc, eff_addr, link_val;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flow_addr_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .pc(pc), .base_val(base_val),
    .r7_val(r7_val), .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p),
    .mem_rdata(mem_rdata), .mem_re(mem_re), .mem_raddr(mem_raddr), .next_pc(next_pc),
    .eff_addr(eff_addr), .ea_valid(ea_valid), .ea_indirect(ea_indirect),
    .link_we(link_we), .link_val(link_val), .done(done)
  );

  function automatic logic [15:0] memf(logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'hC3A5;
  endfunction

  always_ff @(posedge clk) if (mem_re) mem_rdata <= memf(mem_raddr);

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic issue(logic [15:0] ins, logic [15:0] p, logic [15:0] b, logic [15:0] r7,
                       logic [2:0] nzp, bit poke);
    logic [3:0] op;
    logic [15:0] p1, s9, s11, s6, z8, bop, e_npc, e_ea, e_rd;
    bit e_ev, e_ind, e_lw, is_mem, chk_ea, tk;
    string tag;
    op = ins[15:12];
    p1 = p + 16'd1;
    s9 = {{7{ins[8]}}, ins[8:0]};
    s11 = {{5{ins[10]}}, ins[10:0]};
    s6 = {{10{ins[5]}}, ins[5:0]};
    z8 = {8'h00, ins[7:0]};
    bop = (ins[8:6] == 3'd7) ? r7 : b;
    e_npc = p1; e_ea = 16'h0; e_rd = 16'h0;
    e_ev = 0; e_ind = 0; e_lw = 0; is_mem = 0; chk_ea = 0;
    tk = (ins[11] & nzp[2]) | (ins[10] & nzp[1]) | (ins[9] & nzp[0]);
    case (op)
      4'b0000: begin tag = "R2"; if (tk) e_npc = p1 + s9; end
      4'b0010, 4'b0011: begin tag = "R3"; e_ea = p1 + s9; e_ev = 1; chk_ea = 1; end
      4'b1110: begin tag = "R4"; e_ea = p1 + s9; chk_ea = 1; end
      4'b0110, 4'b0111: begin tag = "R5"; e_ea = bop + s6; e_ev = 1; chk_ea = 1; end
      4'b1010, 4'b1011: begin
        tag = "R6"; is_mem = 1; e_rd = p1 + s9; e_ea = memf(e_rd);
        e_ev = 1; e_ind = 1; chk_ea = 1;
      end
      4'b1100: begin tag = "R7"; e_npc = bop; end
      4'b0100: begin tag = "R8"; e_lw = 1; e_npc = ins[11] ? p1 + s11 : bop; end
      4'b1111: begin tag = "R9"; is_mem = 1; e_rd = z8; e_npc = memf(z8); e_lw = 1; end
      default: tag = "R11";
    endcase
    instr = ins; pc = p; base_val = b; r7_val = r7;
    {flag_n, flag_z, flag_p} = nzp; start = 1'b1;
    #1;
    chk("R12", "mem_re", {15'd0, mem_re}, {15'd0, is_mem});
    if (is_mem) chk("R12", "mem_raddr", mem_raddr, e_rd);
    @(negedge clk);
    if (is_mem) begin
      chk("R10", "done early", {15'd0, done}, 16'd0);
      start = poke;
      if (poke) begin
        instr = 16'hC1C0; pc = 16'h7777; r7_val = 16'h1234;
        #1;
        chk("R10", "mem_re busy", {15'd0, mem_re}, 16'd0);
      end
      @(negedge clk);
      start = 1'b0;
    end else begin
      start = 1'b0;
    end
    chk("R10", "done", {15'd0, done}, 16'd1);
    chk(tag, "next_pc", next_pc, e_npc);
    chk(tag, "ea_valid", {15'd0, ea_valid}, {15'd0, e_ev});
    chk(tag, "ea_indirect", {15'd0, ea_indirect}, {15'd0, e_ind});
    chk(tag, "link_we", {15'd0, link_we}, {15'd0, e_lw});
    if (e_lw) chk(tag, "link_val", link_val, p1);
    if (chk_ea) chk(tag, "eff_addr", eff_addr, e_ea);
    @(negedge clk);
    chk("R10", "done after", {15'd0, done}, 16'd0);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; instr = 16'h0; pc = 16'h0; base_val = 16'h0;
    r7_val = 16'h0; flag_n = 0; flag_z = 0; flag_p = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "done", {15'd0, done}, 16'd0);
    chk("R1", "link_we", {15'd0, link_we}, 16'd0);
    chk("R1", "mem_re", {15'd0, mem_re}, 16'd0);
    chk("R1", "next_pc", next_pc, 16'd0);
    chk("R1", "eff_addr", eff_addr, 16'd0);
    chk("R1", "ea_flags", {14'd0, ea_valid, ea_indirect}, 16'd0);
    // R3 worked example
    issue(16'h2BAF, 16'h4018, 16'h0, 16'h0, 3'b010, 0);
    chk("R3", "example", eff_addr, 16'h3FC8);
    // R2 every mask against every flag set
    for (int m = 0; m < 8; m++)
      for (int f = 0; f < 8; f++)
        issue({4'b0000, 3'(m), 9'((m * 67 + f * 29) & 511)}, 16'(16'h3000 + m * 97 + f),
              16'h0, 16'h0, 3'(f), 0);
    // R3 R4 R6 displacement stride, with PC wrap
    for (int o = 0; o < 512; o += 7) begin
      issue({4'b0010, 3'd1, 9'(o)}, 16'(16'hFFF0 + o), 16'h0, 16'h0, 3'b001, 0);
      issue({4'b0011, 3'd2, 9'(o)}, 16'(o * 131), 16'h0, 16'h0, 3'b100, 0);
      issue({4'b1110, 3'd3, 9'(o)}, 16'(16'h8000 + o * 3), 16'h0, 16'h0, 3'b010, 0);
      issue({4'b1010, 3'd4, 9'(o)}, 16'(16'h4000 + o), 16'h0, 16'h0, 3'b010, o[3]);
      issue({4'b1011, 3'd5, 9'(o)}, 16'(16'hFF00 + o), 16'h0, 16'h0, 3'b100, 0);
    end
    // R5 every 6-bit displacement, every base field
    for (int o = 0; o < 64; o++)
      issue({(o[0] ? 4'b0111 : 4'b0110), 3'd1, 3'(o), 6'(o)}, 16'h3000,
            16'(16'hFFE0 + o * 5), 16'(16'h2000 + o), 3'b001, 0);
    // R7 every base field, field 7 is the return form
    for (int r = 0; r < 8; r++)
      issue({4'b1100, 3'd0, 3'(r), 6'd0}, 16'h5000, 16'(16'hA000 + r), 16'h0BEE, 3'b010, 0);
    // R8 long displacement stride and register form
    for (int o = 0; o < 2048; o += 61)
      issue({4'b0100, 1'b1, 11'(o)}, 16'(16'h0300 + o), 16'h0, 16'h0, 3'b100, 0);
    issue({4'b0100, 1'b1, 11'h7FF}, 16'h4000, 16'h0, 16'h0, 3'b100, 0);
    issue({4'b0100, 1'b1, 11'h400}, 16'h0010, 16'h0, 16'h0, 3'b100, 0);
    for (int r = 0; r < 8; r++)
      issue({4'b0100, 1'b0, 2'd0, 3'(r), 6'd0}, 16'h6000, 16'(16'hB100 + r), 16'h7ACE,
            3'b001, 0);
    // R9 every service vector, some with a start while busy (R10)
    for (int v = 0; v < 256; v++)
      issue({4'b1111, 4'd0, 8'(v)}, 16'(16'h3000 + v * 3), 16'h0, 16'h0, 3'b010, v[0]);
    // R11 opcodes outside this unit's work
    issue(16'h1283, 16'h3100, 16'h0, 16'h0, 3'b001, 0);
    issue(16'h5AE0, 16'hFFFF, 16'h0, 16'h0, 3'b001, 0);
    issue(16'h993F, 16'h2222, 16'h0, 16'h0, 3'b100, 0);
    issue(16'h8000, 16'h1000, 16'h0, 16'h0, 3'b010, 0);
    issue(16'hDFFF, 16'h0ABC, 16'h0, 16'h0, 3'b010, 0);
    finished = 1'b1;
    report();
  end
endmodule